// File: doc/BRIEF.md
# Single-Cycle Core with Swap-Add Memory Instruction

This block is a 32-bit single-cycle processor core with a small integer instruction set: register add, subtract, and, or, set-less-than, add-immediate, word load, word store and branch-if-equal. It also has one extra register-format instruction, called swap-add here. In a single cycle, swap-add uses the contents of register `rd` as a data address. It loads the word at that address into register `rt`. It then stores `rs + rt` back at the same address, where `rt` is the value the register held before the cycle.

The instruction and data memories are word arrays inside the core. While reset is held, a testbench or boot loader fills them through two load ports. After reset is released, the core fetches from byte address 0 and commits one instruction on each rising clock edge. Two observation ports read any register and any data word combinationally, and the program counter is brought out as well.

Swap-add needs three source registers, so the register file has a third read port addressed by the `rd` field. New multiplexers steer three paths: the data address, the store data and the write-back value. When any other instruction runs, the swap-add control line is low, and every new multiplexer then selects the path that instruction already used.

Top module: `swap_add_core`

## Requirements
- R1: While `rst_n` is low, on each rising edge the program counter is cleared to 0 and every register is cleared to 0. Memory contents are kept.
- R2: Register instructions use opcode 0 with funct 0x20 add, 0x22 sub, 0x24 and, 0x25 or and 0x2A signed set-less-than. Each writes its result to `rd`. Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0].
- R3: Add-immediate (opcode 0x08) writes `rs + sign_extend(imm[15:0])` to `rt`.
- R4: Load (0x23) and store (0x2B) use the byte address `rs + sign_extend(imm)`. Bits [1:0] of that address are ignored. The load writes to `rt`, and the store writes `rt` to memory.
- R5: Branch-if-equal (0x04) sets the PC to `PC + 4 + (sign_extend(imm) << 2)` when `rs == rt`. Otherwise the PC advances to `PC + 4`.
- R6: Swap-add (opcode 0, funct 0x3F) writes to `rt` the memory word at address `rd` as it was before the cycle.
- R7: Swap-add stores `rs + rt` at address `rd`, using the `rt` value from before the cycle.
- R8: After swap-add the PC advances by 4.
- R9: Register 0 always reads as 0. A write to it has no effect, but a swap-add whose `rt` is 0 still performs its memory store.
- R10: An opcode-0 instruction with an unlisted funct changes no register and no memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; load ports act only while low |
| imem_ld_we | input | 1 | Write enable for the instruction-memory load port |
| imem_ld_addr | input | 6 | Word index for the instruction load |
| dmem_ld_we | input | 1 | Write enable for the data-memory load port |
| dmem_ld_addr | input | 6 | Word index for the data load |
| ld_data | input | 32 | Word written by either load port |
| pc_o | output | 32 | Current program counter |
| dbg_reg_sel | input | 5 | Register index to observe |
| dbg_reg_val | output | 32 | Contents of the selected register |
| dbg_mem_sel | input | 6 | Data-memory word index to observe |
| dbg_mem_val | output | 32 | Contents of the selected data word |

## Verification
The load that fills `rt` and the store that reuses `rt` as an addend fall in the same cycle, and both target the same memory word. The bench provokes this in several ways: a swap-add whose `rs` and `rt` are the same register, a second swap-add back-to-back on the same address, and a swap-add with `rt` equal to 0. Each case is judged two ways. The final register file and data memory are compared against an instruction-level model that always takes old values. A few hand-computed words are also checked, which only come out right if the read happens before the write.

// File: rtl/swap_core_pkg.sv
// Shared encodings and the control word for the swap-add core.
// Assumes the fixed 32-bit instruction layout described in the brief.
package swap_core_pkg;
    localparam logic [5:0] OP_REG  = 6'h00;
    localparam logic [5:0] OP_LOAD = 6'h23;
    localparam logic [5:0] OP_STOR = 6'h2B;
    localparam logic [5:0] OP_BEQ  = 6'h04;
    localparam logic [5:0] OP_ADDI = 6'h08;

    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SWAP = 6'h3F;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;   // commit a register write this cycle
        logic    dst_is_rd;   // destination field: rd (1) or rt (0)
        logic    alu_imm;     // ALU operand B from sign-extended immediate
        logic    mem_write;   // commit a data-memory write this cycle
        logic    wb_from_mem; // write-back value from memory read data
        logic    branch;      // conditional branch on equality
        logic    swap_add;    // swap-add: address from rd port, store ALU sum
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/swap_ctrl_decode.sv
// Main and ALU decoder combined. Produces one control word from opcode and
// funct. Unknown encodings yield an all-zero word, which behaves as a no-op.
// Assumes: purely combinational, no state.
module swap_ctrl_decode
    import swap_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);
    // Decode the instruction class and the ALU function.
    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_ADD;
        unique case (opcode)
            OP_REG: begin
                unique case (funct)
                    FN_ADD: begin ctl.reg_write = 1'b1; ctl.dst_is_rd = 1'b1; ctl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctl.reg_write = 1'b1; ctl.dst_is_rd = 1'b1; ctl.alu_op = ALU_SUB; end
                    FN_AND: begin ctl.reg_write = 1'b1; ctl.dst_is_rd = 1'b1; ctl.alu_op = ALU_AND; end
                    FN_OR:  begin ctl.reg_write = 1'b1; ctl.dst_is_rd = 1'b1; ctl.alu_op = ALU_OR;  end
                    FN_SLT: begin ctl.reg_write = 1'b1; ctl.dst_is_rd = 1'b1; ctl.alu_op = ALU_SLT; end
                    FN_SWAP: begin
                        ctl.reg_write   = 1'b1;
                        ctl.mem_write   = 1'b1;
                        ctl.wb_from_mem = 1'b1;
                        ctl.swap_add    = 1'b1;
                        ctl.alu_op      = ALU_ADD;
                    end
                    default: ctl = '0;
                endcase
            end
            OP_LOAD: begin
                ctl.reg_write   = 1'b1;
                ctl.alu_imm     = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            OP_STOR: begin
                ctl.alu_imm   = 1'b1;
                ctl.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                ctl.alu_op = ALU_SUB;
            end
            OP_ADDI: begin
                ctl.reg_write = 1'b1;
                ctl.alu_imm   = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/swap_alu.sv
// Integer ALU: add, subtract, and, or, signed set-less-than.
// Assumes: combinational; zero flag taken from the result.
module swap_alu
    import swap_core_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] y,
    output logic              zero
);
    // Select the arithmetic or logic result.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/swap_regfile.sv
// Register file with three operand read ports (rs, rt, rd fields) plus an
// observation port. One write port, synchronous, gated off for index 0.
// Assumes: synchronous active-low reset clears all entries.
module swap_regfile #(
    parameter int N_REGS = 32,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(N_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ra_s,
    input  logic [AW-1:0]     ra_t,
    input  logic [AW-1:0]     ra_d,
    input  logic [AW-1:0]     ra_obs,
    output logic [DATA_W-1:0] rd_s,
    output logic [DATA_W-1:0] rd_t,
    output logic [DATA_W-1:0] rd_d,
    output logic [DATA_W-1:0] rd_obs,
    input  logic              we,
    input  logic [AW-1:0]     wa,
    input  logic [DATA_W-1:0] wd
);
    logic [DATA_W-1:0] regs [N_REGS];

    // Clear on reset; otherwise commit a write to any entry except 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REGS; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_s   = regs[ra_s];
    assign rd_t   = regs[ra_t];
    assign rd_d   = regs[ra_d];
    assign rd_obs = regs[ra_obs];

    // R9: entry 0 must never hold anything but zero.
    a_r9_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_s == '0) |-> (rd_s == '0));
endmodule

// File: rtl/swap_data_mem.sv
// Word-addressed data memory: combinational read, synchronous write.
// The core port writes only out of reset; the load port writes only in reset.
// A read in the same cycle as a write returns the old word.
module swap_data_mem #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ld_we,
    input  logic [AW-1:0]     ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [AW-1:0]     obs_addr,
    output logic [DATA_W-1:0] obs_data
);
    logic [DATA_W-1:0] mem [WORDS];

    // Preload during reset, core stores afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (ld_we) mem[ld_addr] <= ld_data;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata    = mem[addr];
    assign obs_data = mem[obs_addr];
endmodule

// File: rtl/swap_add_core.sv
// Single-cycle core top: PC, instruction memory, decoder, three-port register
// file, ALU, data memory and the swap-add steering multiplexers.
// Assumes: instruction memory is preloaded during reset; one instruction
// commits per rising edge once rst_n is high.
module swap_add_core
    import swap_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int N_REGS     = 32,
    localparam int DATA_W    = 32,
    localparam int IAW       = $clog2(IMEM_WORDS),
    localparam int DAW       = $clog2(DMEM_WORDS),
    localparam int RAW       = $clog2(N_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              imem_ld_we,
    input  logic [IAW-1:0]    imem_ld_addr,
    input  logic              dmem_ld_we,
    input  logic [DAW-1:0]    dmem_ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] pc_o,
    input  logic [RAW-1:0]    dbg_reg_sel,
    output logic [DATA_W-1:0] dbg_reg_val,
    input  logic [DAW-1:0]    dbg_mem_sel,
    output logic [DATA_W-1:0] dbg_mem_val
);
    logic [DATA_W-1:0] pc, pc_plus4, pc_next, br_target;
    logic [DATA_W-1:0] imem [IMEM_WORDS];
    logic [DATA_W-1:0] instr, simm;
    logic [RAW-1:0]    f_rs, f_rt, f_rd, wb_addr;
    ctrl_t             ctl;
    logic [DATA_W-1:0] rs_val, rt_val, rd_val;
    logic [DATA_W-1:0] alu_b, alu_y, dmem_addr, dmem_wdata, dmem_rdata, wb_data;
    logic              alu_zero, rf_we, dmem_we;

    // Program counter: cleared in reset, otherwise follows pc_next.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    // Instruction memory preload, only while held in reset.
    always_ff @(posedge clk) begin
        if (!rst_n && imem_ld_we) imem[imem_ld_addr] <= ld_data;
    end

    assign instr = imem[pc[IAW+1:2]];
    assign f_rs  = instr[21+RAW-1:21];
    assign f_rt  = instr[16+RAW-1:16];
    assign f_rd  = instr[11+RAW-1:11];
    assign simm  = {{(DATA_W-16){instr[15]}}, instr[15:0]};

    swap_ctrl_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl)
    );

    assign rf_we   = ctl.reg_write & rst_n;
    assign dmem_we = ctl.mem_write & rst_n;

    swap_regfile #(.N_REGS(N_REGS), .DATA_W(DATA_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_s   (f_rs),
        .ra_t   (f_rt),
        .ra_d   (f_rd),
        .ra_obs (dbg_reg_sel),
        .rd_s   (rs_val),
        .rd_t   (rt_val),
        .rd_d   (rd_val),
        .rd_obs (dbg_reg_val),
        .we     (rf_we),
        .wa     (wb_addr),
        .wd     (wb_data)
    );

    assign alu_b = ctl.alu_imm ? simm : rt_val;

    swap_alu #(.DATA_W(DATA_W)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Swap-add steering: address from the rd port, store data from the ALU sum.
    assign dmem_addr  = ctl.swap_add ? rd_val : alu_y;
    assign dmem_wdata = ctl.swap_add ? alu_y  : rt_val;

    swap_data_mem #(.WORDS(DMEM_WORDS), .DATA_W(DATA_W)) u_dmem (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (dmem_addr[DAW+1:2]),
        .we       (dmem_we),
        .wdata    (dmem_wdata),
        .rdata    (dmem_rdata),
        .ld_we    (dmem_ld_we),
        .ld_addr  (dmem_ld_addr),
        .ld_data  (ld_data),
        .obs_addr (dbg_mem_sel),
        .obs_data (dbg_mem_val)
    );

    // Write-back steering: destination field and value source.
    assign wb_addr = ctl.dst_is_rd ? f_rd : f_rt;
    assign wb_data = ctl.wb_from_mem ? dmem_rdata : alu_y;

    // Next-PC selection.
    assign pc_plus4  = pc + 32'd4;
    assign br_target = pc_plus4 + {simm[DATA_W-3:0], 2'b00};
    assign pc_next   = (ctl.branch && alu_zero) ? br_target : pc_plus4;
    assign pc_o      = pc;

    // R7: swap-add stores rs+rt at the address held in rd.
    a_r7_swap_store: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.swap_add |-> (dmem_we && dmem_addr == rd_val && dmem_wdata == rs_val + rt_val));
    // R6: swap-add loads the memory word into rt.
    a_r6_swap_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.swap_add |-> (rf_we && wb_addr == f_rt && wb_data == dmem_rdata));
    // R8: swap-add advances the PC by one word.
    a_r8_swap_pc: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.swap_add |=> (pc == $past(pc) + 32'd4));
    // R5: taken branch lands on the offset target.
    a_r5_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.branch && rs_val == rt_val) |=> (pc == $past(pc) + 32'd4 + {$past(simm[DATA_W-3:0]), 2'b00}));
endmodule

// File: tb/sim_swap_add_core.sv
// Directed bench: each task loads a program, runs it, and compares the core
// against an instruction-level model kept in the bench.
module sim_swap_add_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_ld_we = 1'b0, dmem_ld_we = 1'b0;
    logic [5:0]  imem_ld_addr = '0, dmem_ld_addr = '0, dbg_mem_sel = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] pc_o, dbg_reg_val, dbg_mem_val;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [31:0] prog [64];
    logic [31:0] init_mem [64];
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [64];
    logic [31:0] m_pc;

    swap_add_core u0 (
        .clk, .rst_n, .imem_ld_we, .imem_ld_addr, .dmem_ld_we, .dmem_ld_addr,
        .ld_data, .pc_o, .dbg_reg_sel, .dbg_reg_val, .dbg_mem_sel, .dbg_mem_val
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] r_ins(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Instruction-level model, always using values from before the step.
    task automatic model_step();
        logic [31:0] ins, a, b, s, r, ld;
        logic [5:0] op, fn;
        int rs, rt, rd;
        ins = prog[m_pc[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        s = {{16{ins[15]}}, ins[15:0]};
        a = m_reg[rs]; b = m_reg[rt];
        m_pc = m_pc + 4;
        case (op)
            6'h00: begin
                r = 'x;
                case (fn)
                    6'h20: r = a + b;
                    6'h22: r = a - b;
                    6'h24: r = a & b;
                    6'h25: r = a | b;
                    6'h2A: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    6'h3F: begin
                        ld = m_mem[m_reg[rd][7:2]];
                        m_mem[m_reg[rd][7:2]] = a + b;
                        if (rt != 0) m_reg[rt] = ld;
                    end
                    default: ;
                endcase
                if (fn inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A} && rd != 0) m_reg[rd] = r;
            end
            6'h08: if (rt != 0) m_reg[rt] = a + s;
            6'h23: if (rt != 0) m_reg[rt] = m_mem[(a + s) >> 2 & 32'h3F];
            6'h2B: m_mem[(a + s) >> 2 & 32'h3F] = b;
            6'h04: if (a == b) m_pc = m_pc + (s << 2);
            default: ;
        endcase
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) begin
            prog[i] = 32'h0;
            init_mem[i] = 32'h1000 + i * 32'h111;
        end
    endtask

    // Load, run for a number of cycles, then compare the whole state.
    task automatic run_case(string req, int cycles);
        @(negedge clk) rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            imem_ld_we = 1'b1; dmem_ld_we = 1'b1;
            imem_ld_addr = i[5:0]; dmem_ld_addr = i[5:0];
            ld_data = prog[i];
            @(negedge clk);
            imem_ld_we = 1'b0;
            ld_data = init_mem[i];
            @(posedge clk);
            #1 dmem_ld_we = 1'b0;
        end
        @(negedge clk);
        imem_ld_we = 1'b0; dmem_ld_we = 1'b0;
        rst_n = 1'b1;
        m_pc = 0;
        for (int i = 0; i < 32; i++) m_reg[i] = 0;
        for (int i = 0; i < 64; i++) m_mem[i] = init_mem[i];
        repeat (cycles) @(posedge clk);
        for (int k = 0; k < cycles; k++) model_step();
        @(negedge clk);
        chk(req, "pc", pc_o, m_pc);
        for (int i = 0; i < 32; i++) begin
            dbg_reg_sel = i[4:0]; #1;
            chk(req, $sformatf("reg%0d", i), dbg_reg_val, m_reg[i]);
        end
        for (int i = 0; i < 64; i++) begin
            dbg_mem_sel = i[5:0]; #1;
            chk(req, $sformatf("mem%0d", i), dbg_mem_val, m_mem[i]);
        end
    endtask

    function automatic logic [31:0] halt_ins();
        return i_ins(6'h04, 0, 0, -1);
    endfunction

    task automatic t_alu(); // R2, R3
        clear_prog();
        prog[0] = i_ins(6'h08, 0, 1, 5);
        prog[1] = i_ins(6'h08, 0, 2, -3);
        prog[2] = r_ins(1, 2, 3, 6'h20);
        prog[3] = r_ins(2, 1, 4, 6'h22);
        prog[4] = r_ins(1, 2, 5, 6'h24);
        prog[5] = r_ins(1, 2, 6, 6'h25);
        prog[6] = r_ins(2, 1, 7, 6'h2A);
        prog[7] = r_ins(1, 2, 8, 6'h2A);
        prog[8] = i_ins(6'h08, 0, 9, 16'h7FFF);
        prog[9] = halt_ins();
        run_case("R2", 20);
        dbg_reg_sel = 5'd4; #1 chk("R2", "sub -3-5", dbg_reg_val, 32'hFFFF_FFF8);
        dbg_reg_sel = 5'd7; #1 chk("R2", "slt signed", dbg_reg_val, 32'd1);
        dbg_reg_sel = 5'd2; #1 chk("R3", "addi negative", dbg_reg_val, 32'hFFFF_FFFD);
    endtask

    task automatic t_mem(); // R4
        clear_prog();
        prog[0] = i_ins(6'h08, 0, 1, 8);
        prog[1] = i_ins(6'h23, 1, 2, 4);
        prog[2] = i_ins(6'h2B, 1, 2, -8);
        prog[3] = i_ins(6'h23, 0, 3, 0);
        prog[4] = i_ins(6'h08, 2, 4, 1);
        prog[5] = i_ins(6'h2B, 1, 4, 20);
        prog[6] = i_ins(6'h23, 1, 5, 2);
        prog[7] = halt_ins();
        run_case("R4", 16);
        dbg_reg_sel = 5'd5; #1 chk("R4", "low address bits ignored", dbg_reg_val, init_mem[2]);
        dbg_mem_sel = 6'd7; #1 chk("R4", "store at offset", dbg_mem_val, init_mem[3] + 1);
    endtask

    task automatic t_branch(); // R5
        clear_prog();
        prog[0] = i_ins(6'h08, 0, 1, 1);
        prog[1] = i_ins(6'h04, 1, 0, 1);
        prog[2] = i_ins(6'h08, 0, 2, 7);
        prog[3] = i_ins(6'h04, 0, 0, 1);
        prog[4] = i_ins(6'h08, 0, 3, 9);
        prog[5] = i_ins(6'h08, 0, 4, 4);
        prog[6] = halt_ins();
        run_case("R5", 14);
        dbg_reg_sel = 5'd2; #1 chk("R5", "not taken falls through", dbg_reg_val, 32'd7);
        dbg_reg_sel = 5'd3; #1 chk("R5", "taken skips", dbg_reg_val, 32'd0);
        chk("R5", "halt pc", pc_o, 32'd24);
    endtask

    task automatic t_swap(); // R6, R7, R8, R9, R10
        clear_prog();
        prog[0] = i_ins(6'h08, 0, 1, 12);
        prog[1] = i_ins(6'h08, 0, 2, 100);
        prog[2] = i_ins(6'h08, 0, 3, 20);
        prog[3] = r_ins(2, 3, 1, 6'h3F);
        prog[4] = r_ins(3, 3, 1, 6'h3F);
        prog[5] = r_ins(2, 0, 1, 6'h3F);
        prog[6] = i_ins(6'h23, 0, 4, 12);
        prog[7] = r_ins(1, 2, 5, 6'h01);
        prog[8] = r_ins(3, 4, 6, 6'h20);
        prog[9] = halt_ins();
        run_case("R6", 20);
        // R6/R7 same cycle: r3 = stored 120 from the first swap-add.
        dbg_reg_sel = 5'd3; #1 chk("R6", "old word into rt", dbg_reg_val, 32'd120);
        // R9: rt=0 keeps zero yet memory is still written with 100+0.
        dbg_reg_sel = 5'd0; #1 chk("R9", "reg0 stays zero", dbg_reg_val, 32'd0);
        dbg_reg_sel = 5'd4; #1 chk("R7", "sum stored with old rt", dbg_reg_val, 32'd100);
        // R10: unknown funct leaves r5 untouched.
        dbg_reg_sel = 5'd5; #1 chk("R10", "unknown funct no write", dbg_reg_val, 32'd0);
        // R8: every swap-add stepped by 4, reaching the halt at 36.
        chk("R8", "pc after swap-adds", pc_o, 32'd36);
    endtask

    task automatic t_reset(); // R1
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "pc in reset", pc_o, 32'd0);
        for (int i = 0; i < 32; i++) begin
            dbg_reg_sel = i[4:0]; #1;
            chk("R1", $sformatf("reg%0d in reset", i), dbg_reg_val, 32'd0);
        end
        dbg_mem_sel = 6'd3; #1 chk("R1", "memory kept", dbg_mem_val, 32'd100);
    endtask

    initial begin
        t_alu();
        t_mem();
        t_branch();
        t_swap();
        t_reset();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule